// File: doc/BRIEF.md
# Two-Slot Half-Block Audio Queue

This block keeps track of the audio blocks waiting to be played on one output channel. It holds at most two block handles: the one being played now and the one queued behind it. A consumer asks for material once per service. Each answer names the handle to read and the sample offset inside that block where the next half-block starts. When no block is present, the answer says to play silence instead. The block never stores or touches sample data. It deals only in handles and in a one-bit record of which half comes next.

When the second half of a block has been handed out, that block is retired. Its handle leaves on a one-cycle release strobe towards the free pool, and the waiting block moves up. A producer may offer a new handle at any time. If both slots are already taken, the oldest block is thrown away and released, the new handle queues behind the survivor, and playback restarts at the first half of the survivor. A push and a service in the same cycle are resolved as if the push happened first.

Top module: `half_block_queue`

## Requirements
- R1: After reset both slots are empty, and `rsp_valid` and `rel_valid` are low.
- R2: A service while the playing slot is empty answers one cycle later with `rsp_silence`=1, `rsp_handle`=0 and `rsp_offset`=0, and releases nothing.
- R3: Successive services of the same block answer with offset 0 and then offset HALF (BLOCK_LEN/2), with the same handle.
- R4: The service that hands out offset HALF also releases that handle, in the same cycle as its answer. The waiting block then becomes the playing block, starting at offset 0, and the waiting slot becomes empty.
- R5: A push while the playing slot is empty puts the handle into the playing slot at offset 0.
- R6: A push while a block is playing and the waiting slot is empty queues the handle behind it and leaves the current offset unchanged.
- R7: A push while both slots are full releases the playing handle one cycle later. The old waiting block then plays from offset 0, and the pushed handle waits behind it.
- R8: When a push and a service occur in the same cycle, the push is applied first and the service then acts on the result. No handle is lost or released twice.
- R9: `rel_valid` is high for exactly one cycle per retired handle, with that handle on `rel_handle`. Service answers and releases appear one cycle after the request.
- R10: With the default BLOCK_LEN of 128, the second-half offset is 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Producer offers a block handle this cycle |
| push_handle | input | HANDLE_W | Handle of the offered block |
| serve | input | 1 | Consumer requests the next half-block |
| rsp_valid | output | 1 | Answer to the service requested in the previous cycle |
| rsp_silence | output | 1 | No block was available; play zeros |
| rsp_handle | output | HANDLE_W | Handle of the block to read |
| rsp_offset | output | $clog2(BLOCK_LEN) | Sample offset of the half-block, 0 or BLOCK_LEN/2 |
| rel_valid | output | 1 | A handle is being returned to the pool |
| rel_handle | output | HANDLE_W | Handle being returned |

## Verification
The hardest condition to reach is a push into a full queue in the same cycle as a service. The eviction and the half-block answer must then agree on which block survives, and the survivor's offset must be reset before the service uses it. The stimulus first fills both slots with pushes alone, then issues a combined push and service while the playing block sits at either half. After that, long random runs with a high push rate keep the queue full most of the time, so every combined case recurs, and a behavioural queue model compares every output on every clock.

// File: rtl/half_block_queue.sv
module half_block_queue #(
  parameter int HANDLE_W  = 8,
  parameter int BLOCK_LEN = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_valid,
  input  logic [HANDLE_W-1:0]          push_handle,
  input  logic                         serve,
  output logic                         rsp_valid,
  output logic                         rsp_silence,
  output logic [HANDLE_W-1:0]          rsp_handle,
  output logic [$clog2(BLOCK_LEN)-1:0] rsp_offset,
  output logic                         rel_valid,
  output logic [HANDLE_W-1:0]          rel_handle
);
  localparam int OFS_W = $clog2(BLOCK_LEN);
  localparam logic [OFS_W-1:0] HALF = OFS_W'(BLOCK_LEN / 2);

  logic                cur_v, nxt_v, half;
  logic [HANDLE_W-1:0] cur_h, nxt_h;

  // state after the push has been applied
  logic                p_cv, p_nv, p_half, evict;
  logic [HANDLE_W-1:0] p_ch, p_nh;
  // state after the service has been applied
  logic                s_cv, s_nv, s_half, retire;
  logic [HANDLE_W-1:0] s_ch, s_nh;

  always_comb begin
    p_cv = cur_v; p_ch = cur_h; p_nv = nxt_v; p_nh = nxt_h; p_half = half; evict = 1'b0;
    if (push_valid) begin
      if (!cur_v) begin
        p_cv = 1'b1; p_ch = push_handle; p_half = 1'b0;
      end else if (!nxt_v) begin
        p_nv = 1'b1; p_nh = push_handle;
      end else begin
        evict = 1'b1; p_ch = nxt_h; p_nh = push_handle; p_half = 1'b0;
      end
    end
    s_cv = p_cv; s_ch = p_ch; s_nv = p_nv; s_nh = p_nh; s_half = p_half; retire = 1'b0;
    if (serve && p_cv) begin
      if (p_half) begin
        retire = 1'b1;
        s_cv = p_nv; s_ch = p_nh; s_nv = 1'b0; s_nh = '0; s_half = 1'b0;
      end else begin
        s_half = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_v <= 1'b0; nxt_v <= 1'b0; half <= 1'b0;
      cur_h <= '0;   nxt_h <= '0;
      rsp_valid <= 1'b0; rsp_silence <= 1'b0; rsp_handle <= '0; rsp_offset <= '0;
      rel_valid <= 1'b0; rel_handle <= '0;
    end else begin
      cur_v <= s_cv; cur_h <= s_ch; nxt_v <= s_nv; nxt_h <= s_nh; half <= s_half;
      rsp_valid   <= serve;
      rsp_silence <= serve && !p_cv;
      rsp_handle  <= (serve && p_cv) ? p_ch : '0;
      rsp_offset  <= (serve && p_cv && p_half) ? HALF : '0;
      rel_valid   <= evict || retire;
      rel_handle  <= evict ? cur_h : (retire ? p_ch : '0);
    end
  end

  assert_offset_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_offset == '0 || rsp_offset == HALF));

  assert_silence_no_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_silence) |-> (!rel_valid && rsp_handle == '0 && rsp_offset == '0));

  assert_second_half_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_silence && rsp_offset == HALF) |-> (rel_valid && rel_handle == rsp_handle));

  assert_fill_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !cur_v && !serve) |=> (cur_v && cur_h == $past(push_handle) && !half));

  assert_queue_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && cur_v && !nxt_v && !serve) |=>
      (nxt_v && nxt_h == $past(push_handle) && half == $past(half)));

  assert_evict_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && cur_v && nxt_v) |=> (rel_valid && rel_handle == $past(cur_h)));

endmodule

// File: tb/half_block_queue_tb.sv
module half_block_queue_tb;
  localparam int HW = 8;
  localparam int BL = 128;
  localparam int OW = $clog2(BL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [HW-1:0] push_handle = '0;
  logic serve = 1'b0;
  logic rsp_valid, rsp_silence, rel_valid;
  logic [HW-1:0] rsp_handle, rel_handle;
  logic [OW-1:0] rsp_offset;

  always #4 clk = ~clk;

  half_block_queue #(.HANDLE_W(HW), .BLOCK_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_handle(push_handle),
    .serve(serve), .rsp_valid(rsp_valid), .rsp_silence(rsp_silence),
    .rsp_handle(rsp_handle), .rsp_offset(rsp_offset),
    .rel_valid(rel_valid), .rel_handle(rel_handle));

  int checks = 0;
  int errors = 0;
  int q[$];
  int m_half = 0;
  int e_rv = 0, e_sil = 0, e_h = 0, e_off = 0, e_relv = 0, e_relh = 0;
  string tag = "R1";
  int cycles = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model(input bit p, input int h, input bit s);
    e_relv = 0; e_relh = 0; e_rv = s; e_sil = 0; e_h = 0; e_off = 0;
    tag = s ? "R3" : "R9";
    if (p) begin
      if (q.size() == 0) begin q.push_back(h); m_half = 0; tag = "R5"; end
      else if (q.size() == 1) begin q.push_back(h); tag = "R6"; end
      else begin e_relv = 1; e_relh = q.pop_front(); q.push_back(h); m_half = 0; tag = "R7"; end
      if (s) tag = "R8";
    end
    if (s) begin
      if (q.size() == 0) begin e_sil = 1; tag = "R2"; end
      else begin
        e_h = q[0]; e_off = m_half ? BL/2 : 0;
        if (m_half) begin
          e_relv = 1; e_relh = q.pop_front(); m_half = 0;
          if (!p) tag = "R4";
        end else m_half = 1;
      end
    end
  endtask

  task automatic compare();
    chk(tag, "rsp_valid", int'(rsp_valid), e_rv);
    if (e_rv != 0) begin
      chk(tag, "rsp_silence", int'(rsp_silence), e_sil);
      chk(tag, "rsp_handle", int'(rsp_handle), e_h);
      chk(tag, "rsp_offset", int'(rsp_offset), e_off);
    end
    chk(tag, "rel_valid", int'(rel_valid), e_relv);
    if (e_relv != 0) chk(tag, "rel_handle", int'(rel_handle), e_relh);
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic step(input bit p, input int h, input bit s);
    push_valid = p; push_handle = HW'(h); serve = s;
    model(p, h, s);
    @(negedge clk);
    compare();
    push_valid = 1'b0; serve = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, idle cycle
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "rel_valid", int'(rel_valid), 0);
    step(0, 0, 1);                  // R2: silence when empty
    step(1, 10, 0);                 // R5
    step(0, 0, 1);                  // R3 first half
    step(1, 11, 0);                 // R6: offset kept
    step(0, 0, 1);                  // R4 second half, R10 offset 64
    chk("R10", "second-half offset", int'(rsp_offset), 64);
    step(0, 0, 1);                  // promoted block 11 at offset 0
    step(1, 12, 0);
    step(1, 13, 0);                 // R7: evicts 11
    step(0, 0, 1);
    step(1, 14, 1);                 // R8: evict while at second half, service starts survivor
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    step(1, 15, 1);                 // R8: push into empty with same-cycle service
    step(1, 16, 1);                 // R8: queue behind while second half retires
    step(0, 0, 1);
    step(0, 0, 1);
    step(0, 0, 1);                  // R2 silence again
    for (int i = 0; i < 3000; i++) begin
      bit p = ($urandom % 100) < 45;
      bit s = ($urandom % 100) < 60;
      step(p, int'($urandom % 256), s);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule